// File: doc/BRIEF.md
# MDIO Interrupt Status Logic

This block produces the two interrupt lines of an MDIO management controller. The first line reports link changes: each of a small number of monitor slots points at one PHY in the link-state vector produced by a link poller. When the link bit of the PHY that a slot points at changes, the slot's raw flag is set. If the slot's interrupt enable is also set, the slot's pending flag is set as well, and the pending flag drives the link interrupt line. The second line reports completed user accesses. Each access channel's busy flag is watched, and a 1-to-0 transition sets that channel's done flag. A per-channel mask then decides whether the done flag reaches the access interrupt line.

Software reaches the status through narrow write strobes with their own data buses, and reads the state back on output ports. Writing ones to a pending register clears those flags, in both the raw and the pending copies. An event in the same cycle as a clear takes precedence, so no completion or link change is lost. Both interrupt outputs are levels: each stays high while any pending flag behind it is set.

Top module: `mdio_irq_status`

## Requirements
- R1: While reset is held, and for two clocks after it is released, every raw, pending, mask and slot register reads zero and both interrupt lines are low.
- R2: A change of `link_state_i[p]`, where p is the PHY index held by slot s, sets `link_raw_o[s]` on the next clock, whatever the slot's enable is.
- R3: A link change sets `link_masked_o[s]` only if slot s's enable (`sel_ie_o[s]`) was 1 when the change happened. `link_irq_o` is high exactly when some `link_masked_o` bit is 1.
- R4: A pulse on `sel_wr_i[s]` loads `sel_phy_i` into slot s's PHY index (bits s*PAW upward of `sel_phy_o`) and loads `sel_ie_i` into its enable. No link event is raised for slot s in that cycle, even when the new PHY's link bit differs from the old one.
- R5: A pulse on `link_clr_wr_i` clears bit s of both `link_raw_o` and `link_masked_o` for every 1 in `link_clr_data_i`. Bits written as 0 are left unchanged.
- R6: If a link change for slot s happens in the same cycle as a clear of bit s, the bit stays set.
- R7: A 1-to-0 transition of `go_i[c]` between two clocks sets `done_raw_o[c]`. A rising or steady `go_i` sets nothing.
- R8: `mask_set_wr_i` sets and `mask_clr_wr_i` clears the `done_mask_o` bits that are 1 in `mask_data_i`. Zero bits have no effect. When both strobes are active in the same cycle, the set wins.
- R9: `done_masked_o` equals `done_raw_o & done_mask_o`, and `done_irq_o` is high exactly when some `done_masked_o` bit is 1.
- R10: A pulse on `done_clr_wr_i` clears the `done_raw_o` bits that are 1 in `done_clr_data_i`, unless a busy-flag fall on the same channel happens in the same cycle.
- R11: In the first active clock after reset, each slot takes in its PHY's current link bit without raising an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_state_i | input | NUM_PHY | Link-up bit per PHY from the poller |
| sel_wr_i | input | NUM_SEL | Write strobe per monitor slot |
| sel_phy_i | input | PAW | PHY index written to a slot |
| sel_ie_i | input | 1 | Link interrupt enable written to a slot |
| link_clr_wr_i | input | 1 | Write strobe for the link pending register |
| link_clr_data_i | input | NUM_SEL | Ones clear link flags |
| go_i | input | NUM_CH | Busy flag per user access channel |
| mask_set_wr_i | input | 1 | Mask set strobe |
| mask_clr_wr_i | input | 1 | Mask clear strobe |
| mask_data_i | input | NUM_CH | Mask bits to set or clear |
| done_clr_wr_i | input | 1 | Write strobe for the done pending register |
| done_clr_data_i | input | NUM_CH | Ones clear done flags |
| sel_phy_o | output | NUM_SEL*PAW | PHY index of each slot |
| sel_ie_o | output | NUM_SEL | Link interrupt enable of each slot |
| link_raw_o | output | NUM_SEL | Link raw flags |
| link_masked_o | output | NUM_SEL | Link pending flags |
| done_raw_o | output | NUM_CH | Access-done raw flags |
| done_mask_o | output | NUM_CH | Access-done mask |
| done_masked_o | output | NUM_CH | Access-done pending flags |
| link_irq_o | output | 1 | Link change interrupt level |
| done_irq_o | output | 1 | Access completion interrupt level |

## Verification
The bench builds the block with NUM_PHY=4 (a 2-bit PHY index), two slots and two channels. With these values both slots can watch the same PHY or different ones, and a slot can be moved onto a PHY whose link bit differs from the one it watched before. Random stimulus over a few hundred cycles therefore reaches the collisions that matter: clears that land together with link changes and busy-flag falls, set and clear strobes that land together on the mask, and selection writes that land together with link toggles.

// File: rtl/mdio_irq_pkg.sv
package mdio_irq_pkg;
  // Width of an index into n items (at least one bit).
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mdio_sticky_bits.sv
// Flag register: ones on set_i raise bits, ones on clr_i drop them; set wins.
module mdio_sticky_bits #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    upd = |(set_i | clr_i);
    q_d = (q_r & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/mdio_link_watch.sv
// One monitor slot: PHY index, enable, and previous link sample.
module mdio_link_watch #(
  parameter int NUM_PHY = 32,
  parameter int PAW     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PHY-1:0] link_i,
  input  logic               primed_i,
  input  logic               wr_i,
  input  logic [PAW-1:0]     wr_phy_i,
  input  logic               wr_ie_i,
  output logic [PAW-1:0]     phy_o,
  output logic               ie_o,
  output logic               chg_o,
  output logic               evt_o
);
  logic [PAW-1:0] phy_r;
  logic           ie_r;
  logic           prev_r;
  logic           prev_d;
  logic           cur;
  logic           load;

  always_comb begin
    cur    = link_i[phy_r];
    load   = wr_i | ~primed_i;
    chg_o  = ~load & (cur ^ prev_r);
    evt_o  = chg_o & ie_r;
    prev_d = wr_i ? link_i[wr_phy_i] : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_r <= '0;
      ie_r  <= 1'b0;
    end else if (wr_i) begin
      phy_r <= wr_phy_i;
      ie_r  <= wr_ie_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_r <= 1'b0;
    else        prev_r <= prev_d;
  end

  assign phy_o = phy_r;
  assign ie_o  = ie_r;
endmodule

// File: rtl/mdio_go_fall.sv
// Falling-edge detector on the per-channel busy flags.
module mdio_go_fall #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] go_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] go_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_r <= '0;
    else        go_r <= go_i;
  end

  assign fall_o = go_r & ~go_i;
endmodule

// File: rtl/mdio_irq_status.sv
module mdio_irq_status
  import mdio_irq_pkg::*;
#(
  parameter  int NUM_SEL = 2,
  parameter  int NUM_CH  = 2,
  parameter  int NUM_PHY = 32,
  localparam int PAW     = addr_bits(NUM_PHY)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PHY-1:0]     link_state_i,
  input  logic [NUM_SEL-1:0]     sel_wr_i,
  input  logic [PAW-1:0]         sel_phy_i,
  input  logic                   sel_ie_i,
  input  logic                   link_clr_wr_i,
  input  logic [NUM_SEL-1:0]     link_clr_data_i,
  input  logic [NUM_CH-1:0]      go_i,
  input  logic                   mask_set_wr_i,
  input  logic                   mask_clr_wr_i,
  input  logic [NUM_CH-1:0]      mask_data_i,
  input  logic                   done_clr_wr_i,
  input  logic [NUM_CH-1:0]      done_clr_data_i,
  output logic [NUM_SEL*PAW-1:0] sel_phy_o,
  output logic [NUM_SEL-1:0]     sel_ie_o,
  output logic [NUM_SEL-1:0]     link_raw_o,
  output logic [NUM_SEL-1:0]     link_masked_o,
  output logic [NUM_CH-1:0]      done_raw_o,
  output logic [NUM_CH-1:0]      done_mask_o,
  output logic [NUM_CH-1:0]      done_masked_o,
  output logic                   link_irq_o,
  output logic                   done_irq_o
);
  // Reset: asserted asynchronously, released after two clocks.
  logic [1:0] rst_sync_r;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_r[1];

  // First active cycle after reset only primes the link samples.
  logic primed_r;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) primed_r <= 1'b0;
    else             primed_r <= 1'b1;
  end

  // Link change path
  logic [NUM_SEL-1:0] link_chg;
  logic [NUM_SEL-1:0] link_evt;
  logic [NUM_SEL-1:0] link_clr;
  logic [PAW-1:0]     slot_phy [NUM_SEL];

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_slot
    mdio_link_watch #(
      .NUM_PHY (NUM_PHY),
      .PAW     (PAW)
    ) u_watch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .link_i   (link_state_i),
      .primed_i (primed_r),
      .wr_i     (sel_wr_i[s]),
      .wr_phy_i (sel_phy_i),
      .wr_ie_i  (sel_ie_i),
      .phy_o    (slot_phy[s]),
      .ie_o     (sel_ie_o[s]),
      .chg_o    (link_chg[s]),
      .evt_o    (link_evt[s])
    );
    assign sel_phy_o[s*PAW +: PAW] = slot_phy[s];
  end

  assign link_clr = link_clr_wr_i ? link_clr_data_i : '0;

  mdio_sticky_bits #(.W(NUM_SEL)) u_link_raw (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (link_chg),
    .clr_i (link_clr),
    .q_o   (link_raw_o)
  );

  mdio_sticky_bits #(.W(NUM_SEL)) u_link_pend (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (link_evt),
    .clr_i (link_clr),
    .q_o   (link_masked_o)
  );

  // Access completion path
  logic [NUM_CH-1:0] go_fall;
  logic [NUM_CH-1:0] done_clr;

  mdio_go_fall #(.W(NUM_CH)) u_go_fall (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .go_i   (go_i),
    .fall_o (go_fall)
  );

  assign done_clr = done_clr_wr_i ? done_clr_data_i : '0;

  mdio_sticky_bits #(.W(NUM_CH)) u_done_raw (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (go_fall),
    .clr_i (done_clr),
    .q_o   (done_raw_o)
  );

  // Mask register, set strobe wins over clear strobe
  logic [NUM_CH-1:0] mask_r;
  logic [NUM_CH-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = mask_set_wr_i | mask_clr_wr_i;
    mask_d  = mask_r;
    if (mask_clr_wr_i) mask_d = mask_d & ~mask_data_i;
    if (mask_set_wr_i) mask_d = mask_d | mask_data_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_r <= '0;
    else if (mask_en) mask_r <= mask_d;
  end

  assign done_mask_o   = mask_r;
  assign done_masked_o = done_raw_o & mask_r;
  assign link_irq_o    = |link_masked_o;
  assign done_irq_o    = |done_masked_o;
endmodule

// File: rtl/mdio_irq_status_chk.sv
module mdio_irq_status_chk #(
  parameter int NUM_SEL = 2,
  parameter int NUM_CH  = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SEL-1:0] sel_wr_i,
  input logic [NUM_SEL-1:0] sel_ie_o,
  input logic [NUM_SEL-1:0] link_chg,
  input logic               link_clr_wr_i,
  input logic [NUM_SEL-1:0] link_clr_data_i,
  input logic [NUM_SEL-1:0] link_raw_o,
  input logic [NUM_SEL-1:0] link_masked_o,
  input logic [NUM_CH-1:0]  go_i,
  input logic               mask_set_wr_i,
  input logic               mask_clr_wr_i,
  input logic [NUM_CH-1:0]  mask_data_i,
  input logic               done_clr_wr_i,
  input logic [NUM_CH-1:0]  done_clr_data_i,
  input logic [NUM_CH-1:0]  done_raw_o,
  input logic [NUM_CH-1:0]  done_mask_o
);
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    // R2 and R6: a detected change always lands in the raw flag
    assert_link_raw_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      link_chg[s] |=> link_raw_o[s]);
    assert_link_pend_gated_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(link_masked_o[s]) |-> $past(sel_ie_o[s]));
    assert_sel_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sel_wr_i[s] && !link_raw_o[s]) |=> !link_raw_o[s]);
    assert_link_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (link_clr_wr_i && link_clr_data_i[s] && !link_chg[s])
        |=> (!link_raw_o[s] && !link_masked_o[s]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_done_from_fall_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(done_raw_o[c]) |-> ($past(go_i[c], 2) && !$past(go_i[c])));
    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mask_set_wr_i && mask_data_i[c]) |=> done_mask_o[c]);
    assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mask_clr_wr_i && mask_data_i[c] && !mask_set_wr_i) |=> !done_mask_o[c]);
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!mask_set_wr_i && !mask_clr_wr_i) |=> $stable(done_mask_o[c]));
    assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (done_clr_wr_i && done_clr_data_i[c] && !($past(go_i[c]) && !go_i[c]))
        |=> !done_raw_o[c]);
  end
endmodule

bind mdio_irq_status mdio_irq_status_chk #(
  .NUM_SEL (NUM_SEL),
  .NUM_CH  (NUM_CH)
) u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .sel_wr_i        (sel_wr_i),
  .sel_ie_o        (sel_ie_o),
  .link_chg        (link_chg),
  .link_clr_wr_i   (link_clr_wr_i),
  .link_clr_data_i (link_clr_data_i),
  .link_raw_o      (link_raw_o),
  .link_masked_o   (link_masked_o),
  .go_i            (go_i),
  .mask_set_wr_i   (mask_set_wr_i),
  .mask_clr_wr_i   (mask_clr_wr_i),
  .mask_data_i     (mask_data_i),
  .done_clr_wr_i   (done_clr_wr_i),
  .done_clr_data_i (done_clr_data_i),
  .done_raw_o      (done_raw_o),
  .done_mask_o     (done_mask_o)
);

// File: tb/mdio_irq_status_test.sv
`timescale 1ns/1ps
module mdio_irq_status_test;
  localparam int NS = 2;
  localparam int NC = 2;
  localparam int NP = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] link_state;
  logic [NS-1:0] sel_wr;
  logic [PW-1:0] sel_phy;
  logic          sel_ie;
  logic          link_clr_wr;
  logic [NS-1:0] link_clr_data;
  logic [NC-1:0] go;
  logic          mask_set_wr, mask_clr_wr;
  logic [NC-1:0] mask_data;
  logic          done_clr_wr;
  logic [NC-1:0] done_clr_data;

  logic [NS*PW-1:0] sel_phy_o;
  logic [NS-1:0]    sel_ie_o, link_raw_o, link_masked_o;
  logic [NC-1:0]    done_raw_o, done_mask_o, done_masked_o;
  logic             link_irq_o, done_irq_o;

  always #2.5 clk = ~clk;

  mdio_irq_status #(.NUM_SEL(NS), .NUM_CH(NC), .NUM_PHY(NP)) uut (
    .clk(clk), .rst_n(rst_n), .link_state_i(link_state),
    .sel_wr_i(sel_wr), .sel_phy_i(sel_phy), .sel_ie_i(sel_ie),
    .link_clr_wr_i(link_clr_wr), .link_clr_data_i(link_clr_data),
    .go_i(go), .mask_set_wr_i(mask_set_wr), .mask_clr_wr_i(mask_clr_wr),
    .mask_data_i(mask_data), .done_clr_wr_i(done_clr_wr),
    .done_clr_data_i(done_clr_data), .sel_phy_o(sel_phy_o), .sel_ie_o(sel_ie_o),
    .link_raw_o(link_raw_o), .link_masked_o(link_masked_o),
    .done_raw_o(done_raw_o), .done_mask_o(done_mask_o),
    .done_masked_o(done_masked_o), .link_irq_o(link_irq_o), .done_irq_o(done_irq_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Behavioural reference state
  int m_cnt = 0;
  int m_primed = 0;
  int m_phy[NS], m_ie[NS], m_prev[NS], m_lraw[NS], m_lpend[NS];
  int m_draw[NC], m_mask[NC], m_gold[NC];

  task automatic m_clear();
    m_primed = 0;
    for (int s = 0; s < NS; s++) begin
      m_phy[s] = 0; m_ie[s] = 0; m_prev[s] = 0; m_lraw[s] = 0; m_lpend[s] = 0;
    end
    for (int c = 0; c < NC; c++) begin
      m_draw[c] = 0; m_mask[c] = 0; m_gold[c] = 0;
    end
  endtask

  initial m_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_clear();
    end else if (m_cnt < 2) begin
      m_cnt++;
      m_clear();
    end else begin
      for (int s = 0; s < NS; s++) begin
        int now, chg, clr;
        now = int'(link_state[m_phy[s]]);
        chg = (m_primed != 0 && !sel_wr[s] && now != m_prev[s]) ? 1 : 0;
        clr = (link_clr_wr && link_clr_data[s]) ? 1 : 0;
        if (chg != 0)                  m_lraw[s] = 1;
        else if (clr != 0)             m_lraw[s] = 0;
        if (chg != 0 && m_ie[s] != 0)  m_lpend[s] = 1;
        else if (clr != 0)             m_lpend[s] = 0;
        if (sel_wr[s]) begin
          m_phy[s] = int'(sel_phy);
          m_ie[s]  = int'(sel_ie);
        end
        m_prev[s] = int'(link_state[m_phy[s]]);
      end
      for (int c = 0; c < NC; c++) begin
        if (m_gold[c] == 1 && go[c] == 1'b0) m_draw[c] = 1;
        else if (done_clr_wr && done_clr_data[c]) m_draw[c] = 0;
        m_gold[c] = int'(go[c]);
        if (mask_clr_wr && mask_data[c]) m_mask[c] = 0;
        if (mask_set_wr && mask_data[c]) m_mask[c] = 1;
      end
      m_primed = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int lany, dany;
    lany = 0; dany = 0;
    for (int s = 0; s < NS; s++) begin
      chk($sformatf("R2 link_raw[%0d]", s), int'(link_raw_o[s]), m_lraw[s]);
      chk($sformatf("R3 link_masked[%0d]", s), int'(link_masked_o[s]), m_lpend[s]);
      chk($sformatf("R4 sel_phy[%0d]", s), int'(sel_phy_o[s*PW +: PW]), m_phy[s]);
      chk($sformatf("R4 sel_ie[%0d]", s), int'(sel_ie_o[s]), m_ie[s]);
      lany = lany | m_lpend[s];
    end
    for (int c = 0; c < NC; c++) begin
      chk($sformatf("R7 done_raw[%0d]", c), int'(done_raw_o[c]), m_draw[c]);
      chk($sformatf("R8 done_mask[%0d]", c), int'(done_mask_o[c]), m_mask[c]);
      chk($sformatf("R9 done_masked[%0d]", c), int'(done_masked_o[c]), m_draw[c] & m_mask[c]);
      dany = dany | (m_draw[c] & m_mask[c]);
    end
    chk("R3 link_irq", int'(link_irq_o), lany);
    chk("R9 done_irq", int'(done_irq_o), dany);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle_strobes();
    sel_wr = '0; link_clr_wr = 1'b0; mask_set_wr = 1'b0;
    mask_clr_wr = 1'b0; done_clr_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; link_state = 4'b0001; sel_wr = '0; sel_phy = '0; sel_ie = 1'b0;
    link_clr_wr = 1'b0; link_clr_data = '0; go = '0; mask_set_wr = 1'b0;
    mask_clr_wr = 1'b0; mask_data = '0; done_clr_wr = 1'b0; done_clr_data = '0;
    repeat (4) cyc();
    chk("R1 reset link_raw", int'(link_raw_o), 0);
    chk("R1 reset done_mask", int'(done_mask_o), 0);
    chk("R1 reset irqs", int'({link_irq_o, done_irq_o}), 0);
    rst_n = 1'b1;
    repeat (5) cyc();
    chk("R11 priming raises no link event", int'(link_raw_o), 0);

    link_state = 4'b0000; cyc();
    chk("R2 both slots on PHY 0 see change", int'(link_raw_o), 3);
    chk("R3 no pending without enable", int'(link_masked_o), 0);

    link_clr_wr = 1'b1; link_clr_data = 2'b01; cyc(); idle_strobes();
    chk("R5 clear bit 0 only", int'(link_raw_o), 2);
    link_clr_wr = 1'b1; link_clr_data = 2'b10; cyc(); idle_strobes();

    link_state = 4'b0100; cyc();
    sel_wr = 2'b01; sel_phy = 2'd2; sel_ie = 1'b1; cyc(); idle_strobes();
    chk("R4 move slot 0 raises nothing", int'(link_raw_o), 0);
    chk("R4 slot 0 PHY index", int'(sel_phy_o[1:0]), 2);

    link_state = 4'b0000; cyc();
    chk("R3 enabled change pends", int'(link_masked_o), 1);
    chk("R3 link irq high", int'(link_irq_o), 1);

    link_state = 4'b0100; link_clr_wr = 1'b1; link_clr_data = 2'b01; cyc(); idle_strobes();
    chk("R6 event beats clear", int'(link_masked_o), 1);
    link_clr_wr = 1'b1; link_clr_data = 2'b01; cyc(); idle_strobes();
    chk("R5 clear drops link irq", int'(link_irq_o), 0);

    sel_wr = 2'b10; sel_phy = 2'd3; sel_ie = 1'b0; cyc(); idle_strobes();
    link_state = 4'b1100; cyc();
    chk("R3 slot 1 raw without pending", int'({link_raw_o[1], link_masked_o[1]}), 2);

    go = 2'b01; repeat (3) cyc();
    chk("R7 rising GO sets nothing", int'(done_raw_o), 0);
    go = 2'b00; cyc();
    chk("R7 GO fall sets done", int'(done_raw_o), 1);
    chk("R9 masked off", int'(done_irq_o), 0);

    mask_set_wr = 1'b1; mask_data = 2'b01; cyc(); idle_strobes();
    chk("R9 done irq after unmask", int'(done_irq_o), 1);
    mask_set_wr = 1'b1; mask_data = 2'b00; cyc(); idle_strobes();
    mask_clr_wr = 1'b1; mask_data = 2'b00; cyc(); idle_strobes();
    chk("R8 zero bits ignored", int'(done_mask_o), 1);
    mask_set_wr = 1'b1; mask_clr_wr = 1'b1; mask_data = 2'b10; cyc(); idle_strobes();
    chk("R8 set beats clear", int'(done_mask_o), 3);
    mask_clr_wr = 1'b1; mask_data = 2'b01; cyc(); idle_strobes();
    chk("R8 clear bit 0", int'(done_mask_o), 2);

    done_clr_wr = 1'b1; done_clr_data = 2'b01; cyc(); idle_strobes();
    chk("R10 clear done 0", int'(done_raw_o), 0);
    go = 2'b10; cyc();
    go = 2'b00; done_clr_wr = 1'b1; done_clr_data = 2'b10; cyc(); idle_strobes();
    chk("R10 fall beats clear", int'(done_raw_o), 2);

    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom);
      link_state    = NP'($urandom);
      go            = NC'($urandom);
      sel_wr        = ((r & 15) == 0) ? NS'($urandom) : '0;
      sel_phy       = PW'($urandom);
      sel_ie        = r[4];
      link_clr_wr   = r[5] & r[6];
      link_clr_data = NS'($urandom);
      mask_set_wr   = r[7] & r[8];
      mask_clr_wr   = r[9] & r[10];
      mask_data     = NC'($urandom);
      done_clr_wr   = r[11] & r[12];
      done_clr_data = NC'($urandom);
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule